// File: doc/BRIEF.md
# Radix-16 Sequential Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their exact `2*WIDTH`-bit signed product. It is iterative: a start pulse on an idle block latches both operands, and the block then works through four multiplier bits per clock until the product is complete. `WIDTH` must be a multiple of four. With the default `WIDTH = 16`, one multiply takes four iterations.

Each iteration splits the four fresh multiplier bits into two overlapping radix-4 Booth digits. Each digit reads its own pair of bits and the bit just below them. The lower digit picks a partial term of 0, ±M or ±2M. The upper digit picks 0, ±4M or ±8M, where M is the multiplicand. Multiplexers choose the two magnitudes first. The accumulator then feeds them through a chain of exactly two adder/subtractors. The accumulator/multiplier pair shifts right arithmetically by four bits, and a down counter loaded at start decides when the operation ends.

The block is not pipelined and runs one multiplication at a time. A start pulse that arrives while an operation is in flight has no effect. When the product is ready, the `done` output rises. The product and `done` then hold until the next start is accepted.

Top module: `mul_booth_r16`

## Requirements
- R1: While `rst_n` is low and directly after reset, `done` is 0 and `product` is 0.
- R2: A cycle with `start` high while no operation is running latches `mcand_in` and `mplier_in` at that clock edge. `done` reads 0 after that edge.
- R3: If a start is accepted at edge k, `done` stays 0 through edge k+WIDTH/4-1 and is 1 after edge k+WIDTH/4.
- R4: When `done` is 1, `product` equals the signed product of the two latched operands, sign-correct over the full 2*WIDTH bits. This includes zero, ±1, and the most-negative value on either input or on both inputs.
- R5: A `start` pulse while an operation is running is ignored. The running operation keeps its operands, and its result and completion cycle are unchanged.
- R6: While no start is accepted, `done` and `product` stay stable, whatever `mcand_in` and `mplier_in` do.
- R7: The accumulator is WIDTH+4 bits wide, so a term of ±8M (including 8 times the most-negative multiplicand) never overflows it. Multiplier nibbles 1000 and 0111 produce the -8M and +8M upper digits.
- R8: A start in a cycle where `done` is 1 is accepted. `done` falls after that edge, and the new result follows per R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply; honoured only while idle |
| mcand_in | input | WIDTH | Signed multiplicand, latched on an accepted start |
| mplier_in | input | WIDTH | Signed multiplier, latched on an accepted start |
| product | output | 2*WIDTH | Signed product, valid while `done` is 1 |
| done | output | 1 | High once the product is complete, until the next accepted start |

## Verification
The bench drives inputs on falling edges and samples on falling edges. Counted from the edge that accepts a start, `done` must still read low one cycle later and again WIDTH/4-1 cycles later, and must read high exactly WIDTH/4 cycles later; the product is compared against a behavioural signed multiply in that same sample. For the ignored-start case, a second pulse is injected one cycle into an operation, and both the completion cycle and the original result are checked. For the hold case, `done` and `product` are re-sampled five cycles after completion, while the operand inputs are being toggled.

// File: rtl/mul_booth_pkg.sv
package mul_booth_pkg;

    typedef enum logic [2:0] {
        DG_ZERO,
        DG_POS1,
        DG_POS2,
        DG_NEG1,
        DG_NEG2
    } booth_dig_e;

    // Radix-4 Booth digit from {b(i+1), b(i), b(i-1)}
    function automatic booth_dig_e decode_group(input logic [2:0] grp);
        booth_dig_e d;
        case (grp)
            3'b001, 3'b010: d = DG_POS1;
            3'b011:         d = DG_POS2;
            3'b100:         d = DG_NEG2;
            3'b101, 3'b110: d = DG_NEG1;
            default:        d = DG_ZERO;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/booth_term_mux.sv
module booth_term_mux
    import mul_booth_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int ACC_W = WIDTH + 4,
    parameter int SH    = 0
) (
    input  logic [2:0]             grp,
    input  logic signed [WIDTH-1:0] mcand,
    output logic [ACC_W-1:0]        mag,
    output logic                    sub
);
    localparam int EXT_W = ACC_W - WIDTH;

    logic [ACC_W-1:0] ext;
    booth_dig_e       dig;

    assign ext = {{EXT_W{mcand[WIDTH-1]}}, mcand};
    assign dig = decode_group(grp);

    // magnitude is selected here; the sign is applied by the adder downstream
    always_comb begin
        mag = '0;
        sub = 1'b0;
        case (dig)
            DG_POS1: mag = ext << SH;
            DG_POS2: mag = ext << (SH + 1);
            DG_NEG1: begin mag = ext << SH;       sub = 1'b1; end
            DG_NEG2: begin mag = ext << (SH + 1); sub = 1'b1; end
            default: begin mag = '0;              sub = 1'b0; end
        endcase
    end

endmodule

// File: rtl/mul_booth_r16.sv
module mul_booth_r16
    import mul_booth_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     mcand_in,
    input  logic [WIDTH-1:0]     mplier_in,
    output logic [2*WIDTH-1:0]   product,
    output logic                 done
);
    localparam int ACC_W  = WIDTH + 4;
    localparam int STEPS  = WIDTH / 4;
    localparam int CNT_W  = $clog2(STEPS + 1);
    localparam int CAT_W  = ACC_W + WIDTH;
    localparam int NDIG   = 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [WIDTH-1:0] mq;
        logic             prev;
        logic [WIDTH-1:0] mcand;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             ready;
    } mul_state_t;

    mul_state_t st_q, st_d;

    logic [2:0]       grp [NDIG];
    logic [ACC_W-1:0] mag [NDIG];
    logic             sub [NDIG];

    assign grp[0] = {st_q.mq[1:0], st_q.prev};
    assign grp[1] = st_q.mq[3:1];

    // digit 0 selects 0/1/2 * M, digit 1 selects 0/4/8 * M
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        booth_term_mux #(
            .WIDTH (WIDTH),
            .ACC_W (ACC_W),
            .SH    (2 * g)
        ) term_i (
            .grp   (grp[g]),
            .mcand (st_q.mcand),
            .mag   (mag[g]),
            .sub   (sub[g])
        );
    end

    logic [ACC_W-1:0]        sum1_d, sum2_d;
    logic signed [CAT_W-1:0] cat_d, cat_sh_d;
    logic                    accept;

    assign accept = start && !st_q.busy;

    always_comb begin
        st_d   = st_q;
        // the only two adder/subtractors in the datapath
        sum1_d = sub[0] ? (st_q.acc - mag[0]) : (st_q.acc + mag[0]);
        sum2_d = sub[1] ? (sum1_d   - mag[1]) : (sum1_d   + mag[1]);
        cat_d    = {sum2_d, st_q.mq};
        cat_sh_d = cat_d >>> 4;

        if (accept) begin
            st_d.acc   = '0;
            st_d.mq    = mplier_in;
            st_d.prev  = 1'b0;
            st_d.mcand = mcand_in;
            st_d.cnt   = CNT_W'(STEPS);
            st_d.busy  = 1'b1;
            st_d.ready = 1'b0;
        end else if (st_q.busy) begin
            st_d.acc  = cat_sh_d[CAT_W-1:WIDTH];
            st_d.mq   = cat_sh_d[WIDTH-1:0];
            st_d.prev = st_q.mq[3];
            st_d.cnt  = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy  = 1'b0;
                st_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign product = {st_q.acc[WIDTH-1:0], st_q.mq};
    assign done    = st_q.ready;

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt > CNT_W'(1)) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R3
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt == CNT_W'(1)) |=> (done && !st_q.busy));

    // R5
    ignore_busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start) |=> $stable(st_q.mcand));

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product)));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ((&st_q.acc[ACC_W-1:WIDTH-1]) || !(|st_q.acc[ACC_W-1:WIDTH-1])));

    // R2
    busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.busy, st_q.ready}));

endmodule

// File: tb/mul_booth_r16_tb.sv
module mul_booth_r16_tb_top;
    localparam int W     = 16;
    localparam int STEPS = W / 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   mcand_in = '0;
    logic [W-1:0]   mplier_in = '0;
    logic [2*W-1:0] product;
    logic           done;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mul_booth_r16 #(.WIDTH(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .product   (product),
        .done      (done)
    );

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [2*W-1:0] ea, eb, p;
        ea = {{W{a[W-1]}}, a};
        eb = {{W{b[W-1]}}, b};
        p  = ea * eb;
        return p;
    endfunction

    task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One multiply; optional ignored start injected one cycle in (R5)
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
        logic [2*W-1:0] exp;
        exp = ref_mul(a, b);
        @(negedge clk);
        start = 1'b1; mcand_in = a; mplier_in = b;
        @(negedge clk);                   // edge k passed
        start = 1'b0;
        mcand_in = ~a; mplier_in = b ^ 16'h5a5a;
        check("R2 done low after start", {31'd0, done}, 32'd0);
        if (poke) begin
            @(negedge clk);               // edge k+1 passed
            start = 1'b1; mcand_in = 16'h1234; mplier_in = 16'h4321;
            @(negedge clk);               // edge k+2 passed
            start = 1'b0;
            repeat (STEPS - 3) @(negedge clk);
        end else begin
            repeat (STEPS - 1) @(negedge clk);
        end
        check("R3 done low one cycle early", {31'd0, done}, 32'd0);
        @(negedge clk);
        check(poke ? "R5 done on time despite busy start" : "R3 done on time", {31'd0, done}, 32'd1);
        check(poke ? "R5 original result kept" : "R4 product", product, exp);
    endtask

    initial begin
        logic [W-1:0] dir_a [14];
        logic [W-1:0] dir_b [14];
        void'($urandom(32'd20240611));
        dir_a = '{16'h0000, 16'h1234, 16'h0001, 16'hffff, 16'h8000, 16'h7fff,
                  16'h8000, 16'h7fff, 16'h8000, 16'h7fff, 16'h8000, 16'h8000, 16'hffff, 16'h0003};
        dir_b = '{16'h5678, 16'h0000, 16'hbeef, 16'h1357, 16'h1234, 16'h8000,
                  16'h8000, 16'h7fff, 16'hffff, 16'h8000, 16'h8888, 16'h7777, 16'h8000, 16'h0001};
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done in reset", {31'd0, done}, 32'd0);
        check("R1 product in reset", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        check("R1 product after reset", product, '0);

        // R4 / R7 directed corners (0x8888 and 0x7777 drive the -8M/+8M digits)
        for (int i = 0; i < 14; i++) run_op(dir_a[i], dir_b[i], 1'b0);

        // R5 ignored start while busy
        run_op(16'hc001, 16'h7ff3, 1'b1);
        run_op(16'h8000, 16'h8000, 1'b1);

        // R6 hold with toggling inputs
        repeat (5) begin
            @(negedge clk);
            mcand_in = W'($urandom); mplier_in = W'($urandom);
        end
        check("R6 done held", {31'd0, done}, 32'd1);
        check("R6 product held", product, ref_mul(16'h8000, 16'h8000));

        // R8 start while done is high, immediately followed by the run (done high now)
        run_op(16'h0005, 16'hfffb, 1'b0);
        run_op(16'h8001, 16'h0002, 1'b0);

        // random operands
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            if (i % 17 == 0) ra = 16'h8000;
            if (i % 23 == 0) rb = 16'h8000;
            run_op(ra, rb, (i % 9 == 0));
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule